// File: doc/BRIEF.md
# Translation Fault Capture and Exception Vectoring

This block sits next to an address translation buffer and reacts to the result of every lookup. For each attempt it receives whether the lookup hit, the valid and dirty bits of the matching entry, and whether the access is a store. It also receives the faulting virtual address and the program counter of the instruction. It sorts the outcome into one of five classes: no fault, refill miss, invalid load, invalid store or write-protection fault.

When a fault occurs, the block records the state that a handler needs. It stores the instruction's PC, a cause code and the bad virtual address. It also loads the page-number field of the staging high word that software later writes into the buffer. It then pushes the mode and interrupt-enable stack, so the processor enters kernel mode with interrupts off. One cycle later it presents a redirect pulse with the target address.

Refill misses on user-half addresses go to a short dedicated handler entry. Every other translation fault goes to the general handler entry. A return-from-exception request pops the mode stack.

Top module: `tlb_fault_vector`

## Requirements
- R1: After reset, epcOut, causeOut, badAddrOut and vpnOut are 0, vecValid is 0, vecPc is 0 and statusOut is 6'b000011. statusOut packs three {user, intEn} pairs, in this order: oldest at bits [5:4], previous at bits [3:2], current at bits [1:0]. A user bit of 1 means user mode and an intEn bit of 1 means interrupts are enabled.
- R2: An attempt that hits an entry with valid=1 is not a fault when it is a load, or when it is a store with dirty=1. No recorded register and no status bit changes, and vecValid stays 0.
- R3: An attempt with tlbHit=0 is a refill miss. Its cause code is 2 for a load and 3 for a store.
- R4: A refill miss on an address with bit 31 clear (0x00000000 to 0x7FFFFFFF) redirects to 0x80000000.
- R5: A refill miss on an address with bit 31 set, such as 0xC0000000 and above, redirects to 0x80000080.
- R6: A hit with valid=0 is an invalid-access fault. Its cause code is 2 for a load and 3 for a store, and it redirects to 0x80000080.
- R7: A store that hits a valid entry with dirty=0 is a write-protection fault. Its cause code is 1 and it redirects to 0x80000080.
- R8: On any fault, epcOut takes curPc, badAddrOut takes faultAddr and vpnOut takes faultAddr[31:12]. All three hold their values until the next fault.
- R9: On any fault, statusOut shifts left by two bits: the previous pair moves to oldest, the current pair moves to previous, and the current pair becomes 2'b00 (kernel mode, interrupts off).
- R10: When rfeReq is high without a fault, the current pair takes the previous pair, the previous pair takes the oldest pair, and the oldest pair is unchanged.
- R11: When a fault and rfeReq occur in the same cycle, the fault wins: the status register pushes and does not pop.
- R12: vecValid is high for exactly the one cycle after a faulting attempt, with vecPc holding the target. Otherwise vecValid is 0 and vecPc is 0. When xlateValid is low, all other translation inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlateValid | input | 1 | A translation attempt is presented this cycle |
| tlbHit | input | 1 | Lookup found a matching entry |
| entryValid | input | 1 | Valid bit of the matching entry |
| entryDirty | input | 1 | Dirty (writable) bit of the matching entry |
| isStore | input | 1 | Attempt is a store (0 = load or fetch) |
| faultAddr | input | 32 | Virtual address of the attempt |
| curPc | input | 32 | PC of the instruction making the attempt |
| rfeReq | input | 1 | Return-from-exception request |
| epcOut | output | 32 | Recorded exception PC |
| causeOut | output | 5 | Recorded cause code |
| badAddrOut | output | 32 | Recorded bad virtual address |
| vpnOut | output | 20 | Page-number field of the staging high word |
| statusOut | output | 6 | Mode and interrupt-enable stack |
| vecValid | output | 1 | Redirect pulse |
| vecPc | output | 32 | Redirect target |

## Verification
A misclassified attempt shows up at the ports on the very next cycle. It appears as a wrong cause code, a wrong vecPc, or a missing or extra vecValid pulse. A broken mode stack first shows in statusOut right after the fault or return that damaged it. It can also stay hidden until a later pop brings the corrupted pair to the current position, so nested faults followed by two returns are exercised. Capture registers that fail to hold are caught by checking them again after non-faulting attempts.

// File: rtl/tlb_fault_pkg.sv
package tlb_fault_pkg;
  localparam int CAUSE_W = 5;

  typedef enum logic [2:0] {
    FK_NONE, FK_REFILL, FK_INV_LD, FK_INV_ST, FK_MOD
  } faultKind_e;

  localparam logic [CAUSE_W-1:0] CAUSE_MOD   = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 5'd3;

  typedef struct packed {
    logic               capture;
    logic               pop;
    logic               fastVec;
    logic [CAUSE_W-1:0] cause;
  } faultStb_t;
endpackage

// File: rtl/tlb_fault_ctrl.sv
module tlb_fault_ctrl
  import tlb_fault_pkg::*;
(
  input  logic      xlateValid,
  input  logic      tlbHit,
  input  logic      entryValid,
  input  logic      entryDirty,
  input  logic      isStore,
  input  logic      addrUpper,
  input  logic      rfeReq,
  output faultStb_t stb
);
  faultKind_e kind;

  always_comb begin
    kind = FK_NONE;
    if (xlateValid) begin
      if (!tlbHit)                    kind = FK_REFILL;
      else if (!entryValid)           kind = isStore ? FK_INV_ST : FK_INV_LD;
      else if (isStore && !entryDirty) kind = FK_MOD;
    end
  end

  always_comb begin
    stb.capture = (kind != FK_NONE);
    stb.pop     = rfeReq && (kind == FK_NONE);
    stb.fastVec = (kind == FK_REFILL) && !addrUpper;
    unique case (kind)
      FK_MOD:    stb.cause = CAUSE_MOD;
      FK_INV_ST: stb.cause = CAUSE_STORE;
      FK_REFILL: stb.cause = isStore ? CAUSE_STORE : CAUSE_LOAD;
      default:   stb.cause = CAUSE_LOAD;
    endcase
  end
endmodule

// File: rtl/tlb_fault_path.sv
module tlb_fault_path
  import tlb_fault_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          PAGE_BITS    = 12,
  parameter int          STACK_LEVELS = 3,
  parameter logic [31:0] REFILL_VEC   = 32'h8000_0000,
  parameter logic [31:0] GENERAL_VEC  = 32'h8000_0080,
  parameter logic [5:0]  STATUS_INIT  = 6'b000011,
  localparam int         VPN_W        = ADDR_W - PAGE_BITS,
  localparam int         STAT_W       = 2 * STACK_LEVELS
) (
  input  logic               clk,
  input  logic               rstN,
  input  faultStb_t          stb,
  input  logic [ADDR_W-1:0]  faultAddr,
  input  logic [ADDR_W-1:0]  curPc,
  output logic [ADDR_W-1:0]  epcOut,
  output logic [CAUSE_W-1:0] causeOut,
  output logic [ADDR_W-1:0]  badAddrOut,
  output logic [VPN_W-1:0]   vpnOut,
  output logic [STAT_W-1:0]  statusOut,
  output logic               vecValid,
  output logic [ADDR_W-1:0]  vecPc
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcOut     <= '0;
      causeOut   <= '0;
      badAddrOut <= '0;
      vpnOut     <= '0;
    end else if (stb.capture) begin
      epcOut     <= curPc;
      causeOut   <= stb.cause;
      badAddrOut <= faultAddr;
      vpnOut     <= faultAddr[ADDR_W-1:PAGE_BITS];
    end
  end

  // Mode stack: push shifts toward the oldest slot, pop shifts toward current.
  always_ff @(posedge clk) begin
    if (!rstN)            statusOut <= STATUS_INIT[STAT_W-1:0];
    else if (stb.capture) statusOut <= {statusOut[STAT_W-3:0], 2'b00};
    else if (stb.pop)     statusOut <= {statusOut[STAT_W-1:STAT_W-2], statusOut[STAT_W-1:2]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecPc    <= '0;
    end else begin
      vecValid <= stb.capture;
      vecPc    <= !stb.capture ? '0 :
                  stb.fastVec  ? REFILL_VEC[ADDR_W-1:0] : GENERAL_VEC[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/tlb_fault_vector.sv
module tlb_fault_vector
  import tlb_fault_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xlateValid,
  input  logic               tlbHit,
  input  logic               entryValid,
  input  logic               entryDirty,
  input  logic               isStore,
  input  logic [ADDR_W-1:0]  faultAddr,
  input  logic [ADDR_W-1:0]  curPc,
  input  logic               rfeReq,
  output logic [ADDR_W-1:0]  epcOut,
  output logic [CAUSE_W-1:0] causeOut,
  output logic [ADDR_W-1:0]  badAddrOut,
  output logic [VPN_W-1:0]   vpnOut,
  output logic [5:0]         statusOut,
  output logic               vecValid,
  output logic [ADDR_W-1:0]  vecPc
);
  faultStb_t stb;

  tlb_fault_ctrl uCtrl (
    .xlateValid(xlateValid), .tlbHit(tlbHit), .entryValid(entryValid),
    .entryDirty(entryDirty), .isStore(isStore),
    .addrUpper(faultAddr[ADDR_W-1]), .rfeReq(rfeReq), .stb(stb)
  );

  tlb_fault_path #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .faultAddr(faultAddr), .curPc(curPc),
    .epcOut(epcOut), .causeOut(causeOut), .badAddrOut(badAddrOut),
    .vpnOut(vpnOut), .statusOut(statusOut), .vecValid(vecValid), .vecPc(vecPc)
  );
endmodule

// File: rtl/tlb_fault_vector_chk.sv
module tlb_fault_vector_chk (
  input logic        clk,
  input logic        rstN,
  input logic        xlateValid,
  input logic        tlbHit,
  input logic        entryValid,
  input logic        entryDirty,
  input logic        isStore,
  input logic [31:0] faultAddr,
  input logic [31:0] curPc,
  input logic        rfeReq,
  input logic [31:0] epcOut,
  input logic [5:0]  statusOut,
  input logic        vecValid,
  input logic [31:0] vecPc
);
  logic isFault;
  assign isFault = xlateValid && !(tlbHit && entryValid && !(isStore && !entryDirty));

  a_r12_pulse: assert property (@(posedge clk) disable iff (!rstN)
    isFault |=> vecValid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !isFault |=> !vecValid && $stable(epcOut));
  a_r4_fast: assert property (@(posedge clk) disable iff (!rstN)
    (xlateValid && !tlbHit && !faultAddr[31]) |=> vecPc == 32'h8000_0000);
  a_r8_epc: assert property (@(posedge clk) disable iff (!rstN)
    isFault |=> epcOut == $past(curPc));
  a_r9_push: assert property (@(posedge clk) disable iff (!rstN)
    isFault |=> statusOut[1:0] == 2'b00 && statusOut[3:2] == $past(statusOut[1:0]));
  a_r10_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rfeReq && !isFault) |=> statusOut[1:0] == $past(statusOut[3:2]));
endmodule

bind tlb_fault_vector tlb_fault_vector_chk uChk (
  .clk(clk), .rstN(rstN), .xlateValid(xlateValid), .tlbHit(tlbHit),
  .entryValid(entryValid), .entryDirty(entryDirty), .isStore(isStore),
  .faultAddr(faultAddr), .curPc(curPc), .rfeReq(rfeReq), .epcOut(epcOut),
  .statusOut(statusOut), .vecValid(vecValid), .vecPc(vecPc)
);

// File: tb/tb_tlb_fault_vector.sv
module tb_tlb_fault_vector;
  logic clk = 0, rstN = 0;
  logic xlateValid = 0, tlbHit = 0, entryValid = 0, entryDirty = 0, isStore = 0, rfeReq = 0;
  logic [31:0] faultAddr = 0, curPc = 0;
  logic [31:0] epcOut, badAddrOut, vecPc;
  logic [4:0]  causeOut;
  logic [19:0] vpnOut;
  logic [5:0]  statusOut;
  logic        vecValid;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tlb_fault_vector dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic attempt(logic h, logic v, logic d, logic st, logic [31:0] a,
                         logic [31:0] pc, logic rfe);
    @(negedge clk);
    xlateValid = 1; tlbHit = h; entryValid = v; entryDirty = d; isStore = st;
    faultAddr = a; curPc = pc; rfeReq = rfe;
    @(negedge clk);
    xlateValid = 0; rfeReq = 0; tlbHit = 0; faultAddr = 32'hFFFF_FFFF; curPc = 32'hDEAD_BEEF;
  endtask

  task automatic doRfe();
    @(negedge clk); rfeReq = 1;
    @(negedge clk); rfeReq = 0;
  endtask

  task automatic testReset();
    chk("R1 epc", epcOut, 0); chk("R1 cause", causeOut, 0);
    chk("R1 bad", badAddrOut, 0); chk("R1 vpn", vpnOut, 0);
    chk("R1 vecValid", vecValid, 0); chk("R1 vecPc", vecPc, 0);
    chk("R1 status", statusOut, 6'b000011);
  endtask

  task automatic testHitOk();
    attempt(1, 1, 0, 0, 32'h0000_4000, 32'h100, 0);
    chk("R2 load vec", vecValid, 0); chk("R2 epc", epcOut, 0);
    attempt(1, 1, 1, 1, 32'h0000_5000, 32'h104, 0);
    chk("R2 store vec", vecValid, 0); chk("R2 status", statusOut, 6'b000011);
    chk("R2 bad", badAddrOut, 0);
    // R12: xlateValid low ignores a would-be miss
    @(negedge clk); tlbHit = 0; faultAddr = 32'h1234_0000;
    @(negedge clk);
    chk("R12 idle vec", vecValid, 0); chk("R12 idle bad", badAddrOut, 0);
  endtask

  task automatic testUserRefill();
    attempt(0, 0, 0, 0, 32'h0040_1234, 32'h0040_0010, 0);
    chk("R3 cause load", causeOut, 2); chk("R4 vecPc", vecPc, 32'h8000_0000);
    chk("R12 vecValid", vecValid, 1); chk("R8 epc", epcOut, 32'h0040_0010);
    chk("R8 bad", badAddrOut, 32'h0040_1234); chk("R8 vpn", vpnOut, 20'h00401);
    chk("R9 status", statusOut, 6'b001100);
    @(negedge clk);
    chk("R12 pulse end", vecValid, 0); chk("R12 vecPc zero", vecPc, 0);
    chk("R8 hold epc", epcOut, 32'h0040_0010);
    doRfe();
    chk("R10 status", statusOut, 6'b000011);
  endtask

  task automatic testKernelRefill();
    attempt(0, 0, 0, 1, 32'hC000_2468, 32'h8000_1000, 0);
    chk("R3 cause store", causeOut, 3); chk("R5 vecPc", vecPc, 32'h8000_0080);
    chk("R8 vpn k", vpnOut, 20'hC0002);
    doRfe();
  endtask

  task automatic testInvalid();
    attempt(1, 0, 1, 0, 32'h0000_7000, 32'h200, 0);
    chk("R6 cause ld", causeOut, 2); chk("R6 vec ld", vecPc, 32'h8000_0080);
    doRfe();
    attempt(1, 0, 1, 1, 32'h0000_8000, 32'h204, 0);
    chk("R6 cause st", causeOut, 3); chk("R6 vec st", vecPc, 32'h8000_0080);
    doRfe();
  endtask

  task automatic testModify();
    attempt(1, 1, 0, 1, 32'h0001_9000, 32'h300, 0);
    chk("R7 cause", causeOut, 1); chk("R7 vec", vecPc, 32'h8000_0080);
    chk("R7 valid", vecValid, 1);
    doRfe();
    chk("R10 after mod", statusOut, 6'b000011);
  endtask

  task automatic testNested();
    attempt(0, 0, 0, 0, 32'h0000_1000, 32'h400, 0);
    attempt(0, 0, 0, 0, 32'hC000_0000, 32'h8000_0080, 1);
    chk("R11 fault wins", statusOut, 6'b110000);
    chk("R11 epc", epcOut, 32'h8000_0080);
    doRfe();
    chk("R10 pop1", statusOut, 6'b111100);
    doRfe();
    chk("R10 pop2", statusOut, 6'b111111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testHitOk();
    testUserRefill();
    testKernelRefill();
    testInvalid();
    testModify();
    testNested();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule